// File: doc/BRIEF.md
# Filter Sample Threshold Scheduler

This block paces a filter compute engine that reads its input samples from a circular buffer of 512 entries. It owns the buffer's write pointer and read pointer, and it derives from them the number of samples that have been written but not yet consumed. When that number reaches a programmed threshold, and an optional host start condition has been met, it raises a run request. When the engine reports that a run has finished, the block consumes samples by moving the read pointer forward. The distance moved is one of two programmed decrement values, and a select input picks which one.

Incoming samples arrive on a valid/ready handshake. A sample is accepted in any cycle where `in_valid` and `in_ready` are both high, and it is written at `wr_addr`. The block drops `in_ready` while the buffer is full, which holds off the producer. The producer must keep `in_valid` and its sample steady until the sample is accepted. A restart reloads the pointers so that they start a programmable distance apart. A gap of 0 suits a single filter and a gap of 2 suits a chain of filters. For polyphase channel staggering, a signed start offset is added to the read address, but only while the instruction being executed matches a configured instruction number.

Top module: `ths_sched`

## Requirements
- R1: After `rst_n` is deasserted, `rd_addr` is 0 (when no offset applies), `wr_addr` equals `cfg_reset_gap`, `avail` equals `cfg_reset_gap`, and `run_req` is low unless the gap meets the threshold.
- R2: A handshake (`in_valid` and `in_ready` both high at a rising clock edge) advances `wr_addr` by 1, modulo 512, and increases `avail` by 1.
- R3: `in_ready` is low exactly when `avail` is 511. `in_valid` then has no effect on `wr_addr` or `avail`.
- R4: `avail` equals `wr_addr` minus the read pointer, modulo 512. `run_req` is high exactly when `avail` is at least `cfg_threshold` and the start gate is open.
- R5: A `run_done` at a clock edge moves the read pointer forward by `cfg_dec0` when `dec_sel` is 0, and by `cfg_dec1` when `dec_sel` is 1.
- R6: When the selected decrement is larger than `avail`, a `run_done` consumes only `avail` samples, so `avail` becomes 0 and never wraps.
- R7: When a write and a `run_done` happen at the same edge, `avail` becomes its old value plus 1 minus the amount consumed.
- R8: While `cfg_gate_en` is 1, `run_req` stays low until `host_flag` has been sampled high at some clock edge since the last reset or restart. Once that has happened, `host_flag` going low no longer blocks runs. With `cfg_gate_en` at 0 the gate is always open.
- R9: When `cur_instr` equals `cfg_ofs_instr`, `rd_addr` is the read pointer plus `cfg_ofs_value` (a two's-complement 9-bit number), modulo 512. Otherwise `rd_addr` is the read pointer.
- R10: A `restart` at a clock edge sets the read pointer to 0 and `wr_addr` to `cfg_reset_gap`, and closes the start gate again. It takes priority over a write and a `run_done` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous pointer reload |
| cfg_reset_gap | input | 9 | Write pointer value loaded on reset or restart |
| cfg_threshold | input | 10 | Samples needed before a run is requested |
| cfg_dec0 | input | 10 | Decrement value 0 |
| cfg_dec1 | input | 10 | Decrement value 1 |
| dec_sel | input | 1 | Selects the decrement used on run_done |
| cfg_gate_en | input | 1 | Enables gating of runs by the host flag |
| host_flag | input | 1 | Host start condition |
| cfg_ofs_instr | input | 5 | Instruction number that receives the start offset |
| cfg_ofs_value | input | 9 | Signed start offset |
| cur_instr | input | 5 | Instruction currently being executed |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The buffer can accept a sample |
| run_done | input | 1 | The filter run has finished; consume samples |
| run_req | output | 1 | Request to run the filter set |
| wr_addr | output | 9 | Buffer write address |
| rd_addr | output | 9 | Buffer read address, offset applied |
| avail | output | 9 | Unconsumed sample count |

## Verification
A corrupted pointer shows up at the ports in the cycle after the edge that corrupted it. It appears first as a wrong `wr_addr`, `rd_addr` or `avail`, and then as `run_req` rising too early or too late against the threshold. A wrong clamp or a wrong wrap shows up as `avail` jumping to a value near 511 after a consume. A stuck start latch shows up as `run_req` staying low, or rising, in the wrong phase of a gated start. The bench steps a behavioural model of the pointers in step with the design and compares every output in every cycle, so such a fault is reported in the first cycle it becomes visible.

// File: rtl/ths_pkg.sv
package ths_pkg;
  localparam int ADDR_W  = 9;
  localparam int THR_W   = 10;
  localparam int INSTR_W = 5;
  localparam int OFS_W   = 9;

  typedef enum logic {
    DEC_PRIMARY = 1'b0,
    DEC_ALT     = 1'b1
  } dec_sel_e;
endpackage

// File: rtl/ths_ptr_ctrl.sv
module ths_ptr_ctrl #(
  parameter int ADDR_W = ths_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] cfg_gap,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] consume_amt,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] avail,
  output logic              full
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= cfg_gap;
      rd_ptr <= '0;
    end else if (restart) begin
      wr_ptr <= cfg_gap;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + ONE;
      rd_ptr <= rd_ptr + consume_amt;
    end
  end

  assign avail = wr_ptr - rd_ptr;
  assign full  = (avail == MAX);

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !restart) |=> (wr_ptr == $past(wr_ptr) + ONE));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && consume_amt == '0 && !restart) |=> full);

  assert_restart_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (rd_ptr == '0 && wr_ptr == $past(cfg_gap)));
endmodule

// File: rtl/ths_run_ctrl.sv
module ths_run_ctrl #(
  parameter int ADDR_W = ths_pkg::ADDR_W,
  parameter int THR_W  = ths_pkg::THR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] avail,
  input  logic [THR_W-1:0]  cfg_threshold,
  input  logic [THR_W-1:0]  cfg_dec0,
  input  logic [THR_W-1:0]  cfg_dec1,
  input  ths_pkg::dec_sel_e dec_sel,
  input  logic              run_done,
  input  logic              cfg_gate_en,
  input  logic              host_flag,
  output logic              run_req,
  output logic [ADDR_W-1:0] consume_amt
);
  localparam int CMP_W = (THR_W > ADDR_W) ? THR_W + 1 : ADDR_W + 1;

  logic             started;
  logic             gate_open;
  logic [CMP_W-1:0] avail_w;
  logic [CMP_W-1:0] thr_w;
  logic [CMP_W-1:0] dec_w;
  logic [THR_W-1:0] dec_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          started <= 1'b0;
    else if (restart)    started <= 1'b0;
    else if (host_flag)  started <= 1'b1;
  end

  always_comb begin
    dec_pick = (dec_sel == ths_pkg::DEC_ALT) ? cfg_dec1 : cfg_dec0;
    avail_w  = CMP_W'(avail);
    thr_w    = CMP_W'(cfg_threshold);
    dec_w    = CMP_W'(dec_pick);
    gate_open = !cfg_gate_en || started;
    run_req   = gate_open && (avail_w >= thr_w);
    if (!run_done)           consume_amt = '0;
    else if (dec_w > avail_w) consume_amt = avail;
    else                      consume_amt = dec_w[ADDR_W-1:0];
  end

  assert_run_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_req |-> (CMP_W'(avail) >= CMP_W'(cfg_threshold)));

  assert_consume_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> (consume_amt <= avail));

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_en && $past(restart)) |-> !run_req);
endmodule

// File: rtl/ths_addr_gen.sv
module ths_addr_gen #(
  parameter int ADDR_W  = ths_pkg::ADDR_W,
  parameter int OFS_W   = ths_pkg::OFS_W,
  parameter int INSTR_W = ths_pkg::INSTR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd_ptr,
  input  logic [INSTR_W-1:0] cur_instr,
  input  logic [INSTR_W-1:0] cfg_ofs_instr,
  input  logic [OFS_W-1:0]   cfg_ofs_value,
  output logic [ADDR_W-1:0]  rd_addr
);
  logic [ADDR_W-1:0] ofs_ext;
  logic              hit;

  generate
    if (ADDR_W > OFS_W) begin : g_sext
      assign ofs_ext = {{(ADDR_W-OFS_W){cfg_ofs_value[OFS_W-1]}}, cfg_ofs_value};
    end else begin : g_trunc
      assign ofs_ext = cfg_ofs_value[ADDR_W-1:0];
    end
  endgenerate

  assign hit     = (cur_instr == cfg_ofs_instr);
  assign rd_addr = hit ? (rd_ptr + ofs_ext) : rd_ptr;

  assert_ofs_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_instr != cfg_ofs_instr) |-> (rd_addr == rd_ptr));
endmodule

// File: rtl/ths_sched.sv
module ths_sched #(
  parameter int ADDR_W  = ths_pkg::ADDR_W,
  parameter int THR_W   = ths_pkg::THR_W,
  parameter int INSTR_W = ths_pkg::INSTR_W,
  parameter int OFS_W   = ths_pkg::OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [ADDR_W-1:0]  cfg_reset_gap,
  input  logic [THR_W-1:0]   cfg_threshold,
  input  logic [THR_W-1:0]   cfg_dec0,
  input  logic [THR_W-1:0]   cfg_dec1,
  input  logic               dec_sel,
  input  logic               cfg_gate_en,
  input  logic               host_flag,
  input  logic [INSTR_W-1:0] cfg_ofs_instr,
  input  logic [OFS_W-1:0]   cfg_ofs_value,
  input  logic [INSTR_W-1:0] cur_instr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               run_done,
  output logic               run_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [ADDR_W-1:0]  avail
);
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] consume_amt;
  logic              full;
  logic              wr_fire;
  ths_pkg::dec_sel_e dsel;

  assign in_ready = !full;
  assign wr_fire  = in_valid && in_ready;
  assign dsel     = ths_pkg::dec_sel_e'(dec_sel);

  ths_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_gap(cfg_reset_gap),
    .wr_fire(wr_fire), .consume_amt(consume_amt),
    .wr_ptr(wr_addr), .rd_ptr(rd_ptr), .avail(avail), .full(full)
  );

  ths_run_ctrl #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_run (
    .clk(clk), .rst_n(rst_n), .restart(restart), .avail(avail),
    .cfg_threshold(cfg_threshold), .cfg_dec0(cfg_dec0), .cfg_dec1(cfg_dec1),
    .dec_sel(dsel), .run_done(run_done), .cfg_gate_en(cfg_gate_en),
    .host_flag(host_flag), .run_req(run_req), .consume_amt(consume_amt)
  );

  ths_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .INSTR_W(INSTR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .rd_ptr(rd_ptr), .cur_instr(cur_instr),
    .cfg_ofs_instr(cfg_ofs_instr), .cfg_ofs_value(cfg_ofs_value),
    .rd_addr(rd_addr)
  );

  assert_ready_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && run_done == 1'b0 && !restart) |=> $stable(wr_addr));

  assert_joint_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !restart) |=> (avail == $past(avail) + ADDR_W'(1) - $past(consume_amt)));
endmodule

// File: tb/ths_sched_tb_top.sv
`timescale 1ns/1ps
module ths_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic [8:0] cfg_reset_gap = 9'd2;
  logic [9:0] cfg_threshold = 10'd8;
  logic [9:0] cfg_dec0 = 10'd8;
  logic [9:0] cfg_dec1 = 10'd3;
  logic       dec_sel = 1'b0;
  logic       cfg_gate_en = 1'b0;
  logic       host_flag = 1'b0;
  logic [4:0] cfg_ofs_instr = 5'd31;
  logic [8:0] cfg_ofs_value = 9'd0;
  logic [4:0] cur_instr = 5'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       run_done = 1'b0;
  logic       run_req;
  logic [8:0] wr_addr, rd_addr, avail;

  always #2 clk = ~clk;

  ths_sched dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_reset_gap(cfg_reset_gap),
    .cfg_threshold(cfg_threshold), .cfg_dec0(cfg_dec0), .cfg_dec1(cfg_dec1),
    .dec_sel(dec_sel), .cfg_gate_en(cfg_gate_en), .host_flag(host_flag),
    .cfg_ofs_instr(cfg_ofs_instr), .cfg_ofs_value(cfg_ofs_value),
    .cur_instr(cur_instr), .in_valid(in_valid), .in_ready(in_ready),
    .run_done(run_done), .run_req(run_req), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .avail(avail)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string phase = "R1";

  // Behavioural reference: plain integers, modulo 512
  int m_wr = 0;
  int m_rd = 0;
  bit m_started = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wr = int'(cfg_reset_gap);
      m_rd = 0;
      m_started = 0;
    end else begin
      int av;
      int dec;
      int amt;
      av  = (m_wr - m_rd + 512) % 512;
      dec = dec_sel ? int'(cfg_dec1) : int'(cfg_dec0);
      amt = run_done ? ((dec > av) ? av : dec) : 0;
      if (restart) begin
        m_wr = int'(cfg_reset_gap);
        m_rd = 0;
        m_started = 0;
      end else begin
        if (in_valid && av != 511) m_wr = (m_wr + 1) % 512;
        m_rd = (m_rd + amt) % 512;
        if (host_flag) m_started = 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int av;
      int ofs;
      int exp_rd;
      bit gate;
      av   = (m_wr - m_rd + 512) % 512;
      ofs  = int'($signed(cfg_ofs_value));
      exp_rd = (cur_instr == cfg_ofs_instr) ? ((m_rd + ofs + 512) % 512) : m_rd;
      gate = !cfg_gate_en || m_started;
      chk("avail (R4 R7)", int'(avail), av);
      chk("wr_addr (R2)", int'(wr_addr), m_wr);
      chk("rd_addr (R9)", int'(rd_addr), exp_rd);
      chk("in_ready (R3)", int'(in_ready), (av != 511) ? 1 : 0);
      chk("run_req (R4 R8)", int'(run_req), (gate && av >= int'(cfg_threshold)) ? 1 : 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: reset state with gap 2
    phase = "R1";
    step(1);
    #1;
    chk("R1 reset avail", int'(avail), 2);
    chk("R1 reset rd_addr", int'(rd_addr), 0);
    chk("R1 reset wr_addr", int'(wr_addr), 2);
    step(1);

    phase = "R2";
    in_valid = 1'b1;
    step(10);
    in_valid = 1'b0;
    step(2);

    phase = "R5";
    run_done = 1'b1; dec_sel = 1'b0;
    step(1);
    dec_sel = 1'b1;
    step(1);
    run_done = 1'b0;
    step(2);

    phase = "R6";
    cfg_dec0 = 10'd100; dec_sel = 1'b0; run_done = 1'b1;
    step(1);
    run_done = 1'b0; cfg_dec0 = 10'd8;
    step(2);

    phase = "R7";
    in_valid = 1'b1; dec_sel = 1'b1;
    for (int i = 0; i < 24; i++) begin
      run_done = i[0];
      step(1);
    end
    run_done = 1'b0;

    phase = "R3";
    cfg_threshold = 10'd1000;
    step(530);
    dec_sel = 1'b0; run_done = 1'b1;
    step(1);
    run_done = 1'b0;
    step(12);
    in_valid = 1'b0;
    step(2);

    phase = "R10";
    cfg_reset_gap = 9'd0;
    restart = 1'b1; in_valid = 1'b1; run_done = 1'b1;
    step(1);
    restart = 1'b0; in_valid = 1'b0; run_done = 1'b0;
    step(1);
    #1;
    chk("R10 restart avail", int'(avail), 0);
    step(1);

    phase = "R8";
    cfg_threshold = 10'd4; cfg_gate_en = 1'b1;
    restart = 1'b1;
    step(1);
    restart = 1'b0; in_valid = 1'b1;
    step(6);
    in_valid = 1'b0;
    step(2);
    host_flag = 1'b1;
    step(1);
    host_flag = 1'b0;
    step(3);
    cfg_gate_en = 1'b0;
    step(1);

    phase = "R9";
    cfg_ofs_instr = 5'd3;
    cfg_ofs_value = 9'h1FD;
    for (int k = 0; k < 8; k++) begin
      cur_instr = 5'(k);
      step(1);
    end
    cfg_ofs_value = 9'd5;
    cur_instr = 5'd3;
    step(2);

    phase = "R1";
    cfg_reset_gap = 9'd2;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule